// File: doc/BRIEF.md
# Converter self-calibration sequencer

This block decides when a data converter's self-calibration runs. Once power-on reset is released it waits out a power-up settling interval whose length is chosen by a delay-select pin. It then launches calibration and holds a running indicator high until the calibration engine reports completion. The engine sits outside the block and signals the end of its work with a one-cycle done pulse.

Software or board logic can also ask for a new calibration through a command pin. A request is a run of at least ten consecutive low samples followed by at least ten consecutive high samples. Calibration starts as soon as the tenth high sample is taken; no further falling edge is needed. If the command pin is already high in the first cycle after reset, the automatic power-up calibration is skipped, and only a complete command starts one.

A power-down pin stops all progress. It freezes the settling counter, blocks new starts and aborts a calibration that is in progress. An aborted calibration is remembered and runs again once power-down is released. The settling lengths are parameters given as powers of two, 2^24 and 2^30 cycles by default, so that shorter values can be used in simulation.

Top module: `selfcal_seq_top`

## Requirements
- R1: While `rst_n` is low, `cal_running` is 0.
- R2: With `dly_sel` = 0, `cal_running` rises after exactly 2^SHORT_LOG2 enabled clock edges following reset release. It is still 0 after one edge fewer.
- R3: With `dly_sel` = 1, the settling interval is 2^LONG_LOG2 enabled clock edges instead.
- R4: Clock edges at which `pwr_dn` is 1 are not counted towards the settling interval, including when `pwr_dn` is held high from reset.
- R5: A command (`cal_pin` sampled 0 on at least 10 consecutive edges, then 1 on 10 consecutive edges) raises `cal_running` at the 10th high edge. After only 9 high edges, `cal_running` is still 0.
- R6: A low run shorter than 10 edges followed by 10 or more high edges starts nothing.
- R7: If `cal_pin` is 1 at the first edge after reset release, the power-up calibration does not run; a later valid command still starts calibration.
- R8: `cal_running` stays 1 until `eng_done` is sampled 1, and is 0 from that edge on.
- R9: `pwr_dn` sampled 1 during calibration clears `cal_running` at that edge. Calibration restarts, exactly once, at the first edge at which `pwr_dn` is sampled 0 again.
- R10: `cal_pin` activity during calibration neither ends it nor counts towards a later command. The low and high run counters saturate at 10.
- R11: No calibration starts while `pwr_dn` is 1, and a command given entirely during power-down is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low power-on reset |
| cal_pin | input | 1 | Calibration command pin (low run, then high run) |
| dly_sel | input | 1 | Settling length select: 0 short, 1 long |
| pwr_dn | input | 1 | Power-down request, active high |
| eng_done | input | 1 | One-cycle completion pulse from the calibration engine |
| cal_running | output | 1 | High for the whole calibration |

## Verification
The bench builds the sequencer with SHORT_LOG2 = 4 and LONG_LOG2 = 6. Both settling windows therefore close after 16 and 64 cycles, and the exact start edge of each can be checked against a cycle count. The command length stays at its real value of 10, so the one-short edges on either side of a command (9 high edges, a 5-edge low run) fall within reach. A power-down that spans a complete command, and toggling of the command pin during a calibration, show whether the gating rules hold.

// File: rtl/selfcal_pkg.sv
package selfcal_pkg;

  typedef enum logic [1:0] {
    SQ_SETTLE = 2'd0,
    SQ_IDLE   = 2'd1,
    SQ_RUN    = 2'd2
  } seq_state_t;

  // Length of a settling window whose size is given as a power of two.
  function automatic logic [63:0] span_of(input int unsigned lg);
    return 64'd1 << lg;
  endfunction

  // Saturating increment used by the command run counters.
  function automatic int unsigned sat_next(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/selfcal_pwrup_timer.sv
module selfcal_pwrup_timer #(
  parameter int unsigned SHORT_LOG2 = 24,
  parameter int unsigned LONG_LOG2  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sel,
  output logic expire
);
  localparam int unsigned CW = LONG_LOG2 + 1;
  localparam logic [CW-1:0] SHORT_LAST = CW'(selfcal_pkg::span_of(SHORT_LOG2) - 64'd1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(selfcal_pkg::span_of(LONG_LOG2) - 64'd1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_w;

  assign last_w = sel ? LONG_LAST : SHORT_LAST;
  // The window closes on the enabled edge that would complete the count.
  assign expire = en && (cnt_q >= last_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en && !expire) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R4: a disabled counter keeps its value
  p_freeze_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));

endmodule

// File: rtl/selfcal_cmd_detect.sv
module selfcal_cmd_detect #(
  parameter int unsigned RUN_LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic pin,
  output logic fire
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIM      = CW'(RUN_LEN);
  localparam logic [CW-1:0] HI_FINAL = CW'(RUN_LEN - 1);

  logic [CW-1:0] lo_q, hi_q;
  logic          armed_q;
  logic [CW-1:0] lo_step, hi_step;

  assign lo_step = CW'(selfcal_pkg::sat_next(32'(lo_q), RUN_LEN));
  assign hi_step = CW'(selfcal_pkg::sat_next(32'(hi_q), RUN_LEN));

  // A command completes on the edge that takes the last required high sample.
  assign fire = !clear && pin && armed_q && (hi_q == HI_FINAL);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lo_q    <= '0;
      hi_q    <= '0;
      armed_q <= 1'b0;
    end else if (!pin) begin
      lo_q    <= lo_step;
      hi_q    <= '0;
      armed_q <= (lo_step >= LIM);
    end else begin
      lo_q <= '0;
      if (fire) begin
        hi_q    <= '0;
        armed_q <= 1'b0;
      end else if (armed_q) begin
        hi_q <= hi_step;
      end
    end
  end

  // R10: run counters never pass their limit
  p_runs_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q <= LIM) && (hi_q <= LIM));

  // R5: completion only follows a high sample on the previous edge as well
  p_fire_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(pin));

endmodule

// File: rtl/selfcal_seq_top.sv
module selfcal_seq_top #(
  parameter int unsigned SHORT_LOG2 = 24,
  parameter int unsigned LONG_LOG2  = 30,
  parameter int unsigned CMD_RUN    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_pin,
  input  logic dly_sel,
  input  logic pwr_dn,
  input  logic eng_done,
  output logic cal_running
);
  import selfcal_pkg::*;

  seq_state_t state_q, state_n;
  logic first_q, suppress_q, pend_q;
  logic pend_n;

  // Named internal events
  logic timer_en, dly_done, cmd_fire, det_clear;
  logic pwrup_go, pend_go, abort_now, skip_auto;

  assign timer_en  = (state_q == SQ_SETTLE) && !pwr_dn;
  assign det_clear = pwr_dn || (state_q == SQ_RUN);
  assign skip_auto = suppress_q || (first_q && cal_pin);
  assign pwrup_go  = dly_done && !skip_auto;
  assign pend_go   = (state_q == SQ_IDLE) && pend_q && !pwr_dn;
  assign abort_now = (state_q == SQ_RUN) && pwr_dn;

  selfcal_pwrup_timer #(
    .SHORT_LOG2(SHORT_LOG2),
    .LONG_LOG2 (LONG_LOG2)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (timer_en),
    .sel   (dly_sel),
    .expire(dly_done)
  );

  selfcal_cmd_detect #(
    .RUN_LEN(CMD_RUN)
  ) u_cmd (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(det_clear),
    .pin  (cal_pin),
    .fire (cmd_fire)
  );

  always_comb begin
    state_n = state_q;
    pend_n  = pend_q;
    case (state_q)
      SQ_SETTLE: begin
        if (cmd_fire)      state_n = SQ_RUN;
        else if (dly_done) state_n = skip_auto ? SQ_IDLE : SQ_RUN;
      end
      SQ_IDLE: begin
        if (pend_go || cmd_fire) begin
          state_n = SQ_RUN;
          pend_n  = 1'b0;
        end
      end
      SQ_RUN: begin
        if (abort_now) begin
          state_n = SQ_IDLE;
          pend_n  = 1'b1;
        end else if (eng_done) begin
          state_n = SQ_IDLE;
        end
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SQ_SETTLE;
      first_q    <= 1'b1;
      suppress_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      first_q <= 1'b0;
      if (first_q && cal_pin) suppress_q <= 1'b1;
    end
  end

  assign cal_running = (state_q == SQ_RUN);

  // R11: power-down seen at an edge leaves the sequencer not running
  p_pd_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !cal_running);

  // R8: the engine's done pulse ends the calibration
  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_running && eng_done) |=> !cal_running);

  // R9: an aborted calibration is remembered
  p_abort_pends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_running && pwr_dn) |=> pend_q);

  // R2: every start has a cause: settling expiry, command or pending restart
  p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_running) |-> $past(pwrup_go || cmd_fire || pend_go));

endmodule

// File: tb/selfcal_seq_top_tb.sv
module selfcal_seq_top_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_pin = 1'b0;
  logic dly_sel = 1'b0;
  logic pwr_dn = 1'b0;
  logic eng_done = 1'b0;
  logic cal_running;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int total = 0;
  bit reported = 0;

  typedef struct {
    int    at;
    logic  val;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  selfcal_seq_top #(
    .SHORT_LOG2(4),
    .LONG_LOG2 (6),
    .CMD_RUN   (10)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_pin    (cal_pin),
    .dly_sel    (dly_sel),
    .pwr_dn     (pwr_dn),
    .eng_done   (eng_done),
    .cal_running(cal_running)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    end
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: cal_running=%b expected %b", tag, cyc, act, exp);
    end
  endtask

  // Monitor: compares scoreboard entries as their cycle comes up
  always @(negedge clk) begin
    if (rst_n) begin
      while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
        check(cal_running, sb_q[0].val, sb_q[0].tag);
        void'(sb_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    total++;
    if (total > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      report();
      $finish;
    end
  end

  task automatic expect_at(input int at, input logic val, input string tag);
    exp_t e;
    e.at = at; e.val = val; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic c, input logic sel, input logic pd);
    @(negedge clk);
    rst_n = 1'b0; eng_done = 1'b0;
    cal_pin = c; dly_sel = sel; pwr_dn = pd;
    repeat (3) @(negedge clk);
    check(cal_running, 1'b0, "R1 reset");
    rst_n = 1'b1;
  endtask

  initial begin
    // Test A: short settling, engine completion
    do_reset(1'b0, 1'b0, 1'b0);
    expect_at(15, 1'b0, "R2 one edge before short window");
    expect_at(16, 1'b1, "R2 short window start");
    expect_at(20, 1'b1, "R8 held until done");
    expect_at(21, 1'b0, "R8 done clears");
    expect_at(40, 1'b0, "R8 no rerun");
    wait_cyc(20); eng_done = 1'b1;
    wait_cyc(21); eng_done = 1'b0;
    drain();

    // Test B: long settling
    do_reset(1'b0, 1'b1, 1'b0);
    expect_at(16, 1'b0, "R3 long select ignores short window");
    expect_at(63, 1'b0, "R3 one edge before long window");
    expect_at(64, 1'b1, "R3 long window start");
    expect_at(66, 1'b1, "R8 held until done");
    expect_at(67, 1'b0, "R8 done clears");
    wait_cyc(66); eng_done = 1'b1;
    wait_cyc(67); eng_done = 1'b0;
    drain();

    // Test C: power-down held from reset freezes settling
    do_reset(1'b0, 1'b0, 1'b1);
    expect_at(30, 1'b0, "R4 frozen during power-down");
    expect_at(45, 1'b0, "R4 one edge before shifted window");
    expect_at(46, 1'b1, "R4 shifted window start");
    expect_at(50, 1'b1, "R8 held until done");
    expect_at(51, 1'b0, "R8 done clears");
    wait_cyc(30); pwr_dn = 1'b0;
    wait_cyc(50); eng_done = 1'b1;
    wait_cyc(51); eng_done = 1'b0;
    drain();

    // Test D: command pin high at reset, short low run, valid command, toggling during run
    do_reset(1'b1, 1'b0, 1'b0);
    expect_at(30, 1'b0, "R7 power-up calibration skipped");
    expect_at(50, 1'b0, "R6 short low run rejected");
    expect_at(64, 1'b0, "R5 nine high edges");
    expect_at(65, 1'b1, "R5 command start");
    expect_at(80, 1'b1, "R10 pin toggles ignored during run");
    expect_at(85, 1'b1, "R8 held until done");
    expect_at(86, 1'b0, "R8 done clears");
    expect_at(100, 1'b0, "R10 no command counted during run");
    wait_cyc(30); cal_pin = 1'b0;
    wait_cyc(35); cal_pin = 1'b1;
    wait_cyc(45); cal_pin = 1'b0;
    wait_cyc(55); cal_pin = 1'b1;
    wait_cyc(66); cal_pin = 1'b0;
    wait_cyc(78); cal_pin = 1'b1;
    wait_cyc(85); eng_done = 1'b1;
    wait_cyc(86); eng_done = 1'b0;
    drain();

    // Test E: abort by power-down, command during power-down, restart
    do_reset(1'b0, 1'b0, 1'b0);
    expect_at(20, 1'b1, "R9 running before abort");
    expect_at(21, 1'b0, "R9 abort clears");
    expect_at(45, 1'b0, "R11 command during power-down discarded");
    expect_at(50, 1'b0, "R11 no start while powered down");
    expect_at(51, 1'b1, "R9 restart after power-down");
    expect_at(55, 1'b1, "R8 held until done");
    expect_at(56, 1'b0, "R8 done clears");
    expect_at(70, 1'b0, "R9 restart happens once");
    wait_cyc(20); pwr_dn = 1'b1;
    wait_cyc(22); cal_pin = 1'b0;
    wait_cyc(32); cal_pin = 1'b1;
    wait_cyc(50); pwr_dn = 1'b0;
    wait_cyc(55); eng_done = 1'b1;
    wait_cyc(56); eng_done = 1'b0;
    drain();

    report();
    $finish;
  end

endmodule